// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the serial management bus of an Ethernet PHY. Software controls it through one 32-bit command register. The register holds a start pattern, an opcode, a 5-bit PHY address, a 5-bit register address, a turnaround pattern and a 16-bit data field. When the controller is idle, writing the register starts a frame. The controller sends a preamble of 32 ones. It then shifts the register out MSB first on MDIO, with timing set by an MDC clock that it divides down from the system clock. The register is itself the shift register, so while a frame is in flight it reads back intermediate values.

The start, opcode and turnaround fields are sent exactly as written, whether or not they form a compliant frame. Bit 29 alone decides the direction. If bit 29 is 1, the frame is a read: the controller releases MDIO from the second turnaround bit onward and shifts the 16 returned bits into bits 15:0. If bit 29 is 0, the frame is a write: the register rotates through a full circle and ends holding the value that was written. At the end of every frame an interrupt flag is set. It stays set until software pulses the clear input. The register has no reset value.

Top module: `mdio_frame_master`

## Requirements
- R1: A `cmd_wr` pulse while idle loads `cmd_wdata` and raises `busy` on the next cycle. `busy` stays high until the frame ends, and falls in the same cycle that `irq` rises.
- R2: Each frame begins with 32 MDC periods in which MDIO is driven (`mdio_oe`=1) to 1.
- R3: After the preamble, 32 frame bits follow, register bit 31 first. Bit 31 of the register is sent as frame bit 0, so frame bit k carries register bit 31-k. Non-compliant start, opcode or turnaround values are sent unchanged. A frame has exactly 64 MDC rising edges.
- R4: Bit 29 of the written value selects the direction: 1 gives a read frame and 0 gives a write frame. Bit 28 has no effect on the direction.
- R5: In a read frame, MDIO is driven for frame bits 0 to 14 and released (`mdio_oe`=0) for frame bits 15 to 31. Once released, it is not driven again until the frame ends.
- R6: In a read frame, `mdio_i` is sampled at each MDC rising edge of frame bits 16 to 31. The first sample lands in bit 15. After the frame, bits 31:16 read back as written and bits 15:0 hold the sampled data. The written data field has no effect.
- R7: After a write frame, `cmd_rdata` equals the value that was written, and MDIO is driven for all 64 bits.
- R8: `irq` is set when a frame ends and holds until an `irq_clr` pulse clears it.
- R9: A `cmd_wr` while `busy` is high is ignored. The running frame, its bit count and its final register value are unchanged, and no second frame follows.
- R10: MDC idles low. Each MDC half period lasts `clk_div`+1 system clocks. MDIO changes only while MDC is low, in the cycle of a falling edge.
- R11: After reset, `busy`, `irq`, `mdc` and `mdio_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Value written to the command register |
| cmd_rdata | output | 32 | Current command register contents |
| clk_div | input | DIV_W (8) | MDC half period minus one, in system clocks |
| irq_clr | input | 1 | Pulse to clear the completion flag |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Completion interrupt flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach is the read path, where the PHY must return each bit at exactly the right place. A response is only captured if a bit is presented after the correct MDC fall and held across the following rise. The bench models a PHY that counts MDC falls from the start of each frame and drives the response from the 48th fall onward. It also watches MDIO while the line is released. A write issued in the middle of a frame is the second corner case. The bench shows that it is ignored through the bit count and the final register value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned CMD_W    = 32;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned RD_BIT   = 29;
  localparam int unsigned REL_BIT  = 15;
  localparam int unsigned CNT_W    = $clog2(CMD_W);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PRE   = 2'd1,
    PH_FRAME = 2'd2
  } phase_e;
endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_m1,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap     = run && (cnt_q == half_m1);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10: MDC only toggles on a strobe.
  assert_mdc_toggle_on_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(wrap)) |-> $stable(mdc));
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] load_val,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdio_i,
  output logic [CMD_W-1:0] sr,
  output logic             active,
  output logic             done,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] DATA_LO  = CNT_W'(CMD_W - DATA_W);

  phase_e           phase_q;
  logic [CNT_W-1:0] bit_q;
  logic             is_rd_q;
  logic             samp_q;
  logic             take_in;

  assign active  = (phase_q != PH_IDLE);
  assign done    = (phase_q == PH_FRAME) && fall_stb && (bit_q == LAST_BIT);
  assign take_in = is_rd_q && (bit_q >= DATA_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      is_rd_q <= 1'b0;
      samp_q  <= 1'b1;
    end else begin
      if (rise_stb) samp_q <= mdio_i;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_PRE;
          bit_q   <= '0;
          is_rd_q <= load_val[RD_BIT];
        end
        PH_PRE: if (fall_stb) begin
          if (bit_q == PRE_LAST) begin
            phase_q <= PH_FRAME;
            bit_q   <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        PH_FRAME: if (fall_stb) begin
          if (bit_q == LAST_BIT) begin
            phase_q <= PH_IDLE;
            bit_q   <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // Data register: no defined reset value.
  always_ff @(posedge clk) begin
    if (start && !active)
      sr <= load_val;
    else if ((phase_q == PH_FRAME) && fall_stb)
      sr <= {sr[CMD_W-2:0], take_in ? samp_q : sr[CMD_W-1]};
  end

  always_comb begin
    mdio_o  = 1'b1;
    mdio_oe = 1'b0;
    unique case (phase_q)
      PH_PRE: mdio_oe = 1'b1;
      PH_FRAME: begin
        mdio_o  = sr[CMD_W-1];
        mdio_oe = !is_rd_q || (bit_q < CNT_W'(REL_BIT));
      end
      default: ;
    endcase
  end

  // R10: MDIO only moves on an MDC falling strobe while a frame runs.
  assert_mdio_moves_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(fall_stb)) |-> $stable(mdio_o));

  // R9: a write during a frame does not restart the bit count.
  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start && !fall_stb) |=> (bit_q == $past(bit_q)));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  output logic [31:0]      cmd_rdata,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             irq_clr,
  output logic             busy,
  output logic             irq,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic rise_stb;
  logic fall_stb;
  logic done;

  mdc_clock_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_m1  (clk_div),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_wr),
    .load_val (cmd_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .sr       (cmd_rdata),
    .active   (busy),
    .done     (done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (done)    irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end

  // R1: busy only drops together with the completion flag.
  assert_busy_until_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R8: flag holds without a clear.
  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R5: once released inside a frame, MDIO stays released.
  assert_release_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

  // R10: MDC idles low.
  assert_mdc_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mdc);
endmodule

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {command, PHY response, divider}
  localparam logic [55:0] VECS [NVEC] = '{
    {32'h51FEA5C3, 16'h0000, 8'd0},
    {32'h6F82FFFF, 16'h1234, 8'd1},
    {32'h30890000, 16'hBEEF, 8'd3},
    {32'hCAAB8001, 16'h0F0F, 8'd0},
    {32'hA0000000, 16'h8001, 8'd2},
    {32'h00000000, 16'h5555, 8'd0}
  };

  logic        clk = 0, rst_n = 0, cmd_wr = 0, irq_clr = 0, mdio_i = 1;
  logic [31:0] cmd_wdata = 0;
  logic [7:0]  clk_div = 0;
  logic [31:0] cmd_rdata;
  logic        busy, irq, mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0;
  int rise_n = 0, fall_n = 0, viol = 0;
  logic [63:0] txbits, oebits;
  logic [15:0] cur_resp = 0;

  mdio_frame_master u0 (.clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .clk_div(clk_div), .irq_clr(irq_clr), .busy(busy), .irq(irq),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge mdc) begin
    if (rise_n < 64) begin
      txbits[63-rise_n] = mdio_o;
      oebits[63-rise_n] = mdio_oe;
    end
    rise_n++;
  end

  // PHY model: presents response bit k after fall 32+k.
  always @(negedge mdc) begin
    int k;
    fall_n++;
    k = fall_n - 32;
    if (k >= 16 && k <= 31) mdio_i = cur_resp[31-k];
    else mdio_i = 1'b1;
  end

  always @(mdio_o) begin
    #1;
    if (busy && mdc) viol++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 40000) begin
      @(negedge clk);
      n++;
    end
    if (!irq) begin
      errors++;
      checks++;
      $display("FAIL R8: actual no interrupt expected interrupt (watchdog)");
    end
  endtask

  task automatic start_frame(input logic [31:0] cmd, input logic [15:0] resp);
    rise_n = 0; fall_n = 0; cur_resp = resp;
    @(negedge clk); cmd_wr = 1; cmd_wdata = cmd;
    @(negedge clk); cmd_wr = 0;
    check("R1 busy after write", busy, 1);
  endtask

  task automatic finish_checks(input logic [31:0] cmd, input logic [15:0] resp);
    check("R1 busy low at end", busy, 0);
    check("R3 rising edge count", rise_n, 64);
    check("R2 preamble ones", txbits[63:32], 64'hFFFFFFFF);
    check("R2 preamble driven", oebits[63:32], 64'hFFFFFFFF);
    if (cmd[29]) begin
      check("R3 read header bits", txbits[31:17], cmd[31:17]);
      check("R5 read drive pattern", oebits[31:0], 32'hFFFE0000);
      check("R6 read result", cmd_rdata, {cmd[31:16], resp});
    end else begin
      check("R3 write bits", txbits[31:0], cmd);
      check("R7 write driven", oebits[31:0], 32'hFFFFFFFF);
      check("R7 write readback", cmd_rdata, cmd);
    end
    check("R8 irq set", irq, 1);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check("R8 irq cleared", irq, 0);
  endtask

  initial begin
    int hi;
    #(CLK_PERIOD*3 + 2);
    check("R11 reset busy", busy, 0);
    check("R11 reset irq", irq, 0);
    check("R11 reset mdc", mdc, 0);
    check("R11 reset oe", mdio_oe, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NVEC; i++) begin
      clk_div = VECS[i][7:0];
      start_frame(VECS[i][55:24], VECS[i][23:8]);
      wait_irq();
      finish_checks(VECS[i][55:24], VECS[i][23:8]);
    end
    check("R10 mdio moved with mdc high", viol, 0);

    // R10: half period with divider 2 is 3 clocks.
    clk_div = 8'd2;
    start_frame(32'h51FE0000, 16'h0);
    @(posedge mdc); @(negedge clk);
    hi = 0;
    while (mdc) begin hi++; @(negedge clk); end
    check("R10 mdc high time", hi, 3);
    wait_irq();
    finish_checks(32'h51FE0000, 16'h0);

    // R9: write while busy ignored.
    clk_div = 8'd0;
    start_frame(32'h5123ABCD, 16'h0);
    repeat (40) @(negedge clk);
    cmd_wr = 1; cmd_wdata = 32'h6F820000;
    @(negedge clk); cmd_wr = 0;
    wait_irq();
    check("R9 bit count unchanged", rise_n, 64);
    check("R9 value unchanged", cmd_rdata, 32'h5123ABCD);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    repeat (300) @(negedge clk);
    check("R9 no second frame", {busy, irq}, 0);

    // R4: bit 28 alone does not make a read (opcode 01 write, data kept).
    start_frame(32'h5000FACE, 16'h1111);
    wait_irq();
    check("R4 op 01 is write", cmd_rdata, 32'h5000FACE);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule